// File: doc/BRIEF.md
# Time-Shared FIR Filter Engine

This block produces one output of a finite impulse response filter for every input sample it accepts. Each accepted sample goes into a circular delay line that holds the most recent TAPS samples, and the newest entry replaces the oldest one. The filter taps live in a separate coefficient store. Because the two stores are separate, one tap and one sample are read in the same cycle. A single multiplier and accumulator are shared across all taps. They run one tap per cycle: the coefficient pointer counts upward from tap 0, and the sample pointer walks backward from the newest sample.

When the tap loop ends, the accumulator is shifted right by a fixed amount and clamped to the sample width. The result is then parked in a holding register. It is not released straight away. The parked result is presented on the output when the next sample is accepted. A system that takes samples at a fixed rate therefore sees outputs at that same rate, one sample period late.

The sample input is a valid/ready stream. `in_ready` is high only while the engine is idle, and a sample transfers on a cycle where `in_valid` and `in_ready` are both high. A source that must lose nothing holds its sample until `in_ready` returns. A valid offered while `in_ready` is low is counted as a lost sample and flagged. The output has no back-pressure: a result appears as a one-cycle `out_valid` pulse, and the receiver must take it in that cycle.

Top module: `fir_mac_engine`

## Requirements
- R1: After reset `in_ready` is 1, `out_valid` is 0, `out_data` is 0 and `overrun` is 0, and every delay-line and coefficient entry is zero.
- R2: A cycle with `coef_we` high stores `coef_data` as tap `coef_addr`. Tap 0 multiplies the newest sample, and tap k multiplies the sample accepted k samples earlier.
- R3: For accepted sample n, the result is clamp(S >>> SHIFT). Here S = sum over k of c[k]*x[n-k], a signed 40-bit sum of 16-bit signed products, and a missing earlier sample counts as zero.
- R4: The accumulator starts from zero for every sample, so each result does not depend on earlier results.
- R5: The result for sample n appears on `out_data`, with `out_valid` high, in the cycle after sample n+1 is accepted. The first sample accepted after reset releases no result.
- R6: `out_valid` is high for exactly one cycle per released result, and `out_data` keeps its value between releases.
- R7: After an accepted sample, `in_ready` is low for exactly TAPS+3 cycles (19 with defaults) and then returns high.
- R8: A cycle with `in_valid` high and `in_ready` low drops the offered sample, so it never enters the delay line. `overrun` is high for exactly the following cycle.
- R9: A shifted sum above 32767 is output as 32767, and one below -32768 is output as -32768.
- R10: The delay line keeps only the TAPS most recent accepted samples, so a sample accepted TAPS or more samples ago no longer affects the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Sample offered |
| in_ready | output | 1 | Engine idle, sample will be taken |
| in_data | input | 16 | Signed input sample |
| coef_we | input | 1 | Coefficient write strobe |
| coef_addr | input | 4 | Tap index of the write |
| coef_data | input | 16 | Signed coefficient value |
| out_valid | output | 1 | One-cycle pulse, result released |
| out_data | output | 16 | Signed filter output |
| overrun | output | 1 | Pulse, a sample was dropped in the previous cycle |

## Verification
Each released output is compared against a bench model of the delay line and taps. Because results are held back by one sample, a wrong pointer, coefficient address or accumulator state shows up on the release after the next accepted sample, and no earlier. Sequencing faults show at the ports within one sample period: a busy window of the wrong length is seen as `in_ready` returning high in the wrong cycle, and a leaked dropped sample corrupts the outputs that follow it. The saturation limits are driven with full-scale stimulus.

// File: rtl/fir_pkg.sv
package fir_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_RUN   = 2'd1,
    SEQ_DRAIN = 2'd2
  } seq_state_t;
endpackage

// File: rtl/fir_delay_line.sv
// Circular sample store: one write per accepted sample, one registered read
// port used by the tap loop.
module fir_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic signed [W-1:0] wdata,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic signed [W-1:0] rd_data,
  output logic [AW-1:0]       wr_ptr
);
  logic signed [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      wr_ptr  <= '0;
      rd_data <= '0;
    end else begin
      if (we) begin
        mem[wr_ptr] <= wdata;
        wr_ptr      <= wr_ptr + AW'(1);
      end
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end

  // R10: the write pointer moves by exactly one slot per stored sample
  p_ptr_advance_r10: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (wr_ptr == $past(wr_ptr) + AW'(1)));
endmodule

// File: rtl/fir_coef_mem.sv
// Tap store with an independent write port and a registered read port.
module fir_coef_mem #(
  parameter int W    = 16,
  parameter int TAPS = 16,
  localparam int AW  = $clog2(TAPS)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                we,
  input  logic [AW-1:0]       waddr,
  input  logic signed [W-1:0] wdata,
  input  logic                rd_en,
  input  logic [AW-1:0]       rd_addr,
  output logic signed [W-1:0] rd_data
);
  logic signed [W-1:0] mem [TAPS];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < TAPS; i++) mem[i] <= '0;
      rd_data <= '0;
    end else begin
      if (we) mem[waddr] <= wdata;
      if (rd_en) rd_data <= mem[rd_addr];
    end
  end
endmodule

// File: rtl/fir_mac.sv
// Product register, wide accumulator, then arithmetic shift and clamp.
module fir_mac #(
  parameter int DW    = 16,
  parameter int ACC_W = 40,
  parameter int SHIFT = 15,
  localparam int PW   = 2 * DW
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 in_vld,
  input  logic signed [DW-1:0] a,
  input  logic signed [DW-1:0] b,
  output logic                 pending,
  output logic signed [DW-1:0] result
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((64'sd1 <<< (DW - 1)) - 64'sd1);
  localparam logic signed [ACC_W-1:0] MINV = -MAXV - ACC_W'(1);

  logic signed [PW-1:0]    prod;
  logic                    prod_vld;
  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] shifted;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prod     <= '0;
      prod_vld <= 1'b0;
      acc      <= '0;
    end else begin
      prod_vld <= in_vld;
      if (in_vld) prod <= a * b;
      if (clr) acc <= '0;
      else if (prod_vld) acc <= acc + {{(ACC_W - PW){prod[PW-1]}}, prod};
    end
  end

  assign pending = prod_vld;
  assign shifted = acc >>> SHIFT;

  always_comb begin
    if (shifted > MAXV)      result = MAXV[DW-1:0];
    else if (shifted < MINV) result = MINV[DW-1:0];
    else                     result = shifted[DW-1:0];
  end

  // R3: a product is only presented one cycle after its operands were read
  p_prod_after_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    prod_vld |-> $past(in_vld));
  // R4: a clear leaves the accumulator at zero
  p_acc_cleared_r4: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (acc == '0));
endmodule

// File: rtl/fir_mac_engine.sv
module fir_mac_engine #(
  parameter int DATA_W = 16,
  parameter int ACC_W  = 40,
  parameter int TAPS   = 16,
  parameter int SHIFT  = 15,
  localparam int AW    = $clog2(TAPS),
  localparam int CW    = $clog2(TAPS + 4) + 1
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     in_valid,
  output logic                     in_ready,
  input  logic signed [DATA_W-1:0] in_data,
  input  logic                     coef_we,
  input  logic [AW-1:0]            coef_addr,
  input  logic signed [DATA_W-1:0] coef_data,
  output logic                     out_valid,
  output logic signed [DATA_W-1:0] out_data,
  output logic                     overrun
);
  import fir_pkg::*;

  seq_state_t              state;
  logic [AW-1:0]           tap_cnt, coef_ptr, samp_ptr, wr_ptr;
  logic                    accept, issue, rd_vld, mac_pending;
  logic signed [DATA_W-1:0] samp_q, coef_q, mac_result, hold;
  logic                    hold_full;
  logic [CW-1:0]           busy_cnt;

  assign in_ready = (state == SEQ_IDLE);
  assign accept   = in_valid && in_ready;
  assign issue    = (state == SEQ_RUN);

  fir_delay_line #(.W(DATA_W), .DEPTH(TAPS)) i_delay (
    .clk(clk), .rst_n(rst_n), .we(accept), .wdata(in_data),
    .rd_en(issue), .rd_addr(samp_ptr), .rd_data(samp_q), .wr_ptr(wr_ptr));

  fir_coef_mem #(.W(DATA_W), .TAPS(TAPS)) i_coef (
    .clk(clk), .rst_n(rst_n), .we(coef_we), .waddr(coef_addr),
    .wdata(coef_data), .rd_en(issue), .rd_addr(coef_ptr), .rd_data(coef_q));

  fir_mac #(.DW(DATA_W), .ACC_W(ACC_W), .SHIFT(SHIFT)) i_mac (
    .clk(clk), .rst_n(rst_n), .clr(accept), .in_vld(rd_vld),
    .a(coef_q), .b(samp_q), .pending(mac_pending), .result(mac_result));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state     <= SEQ_IDLE;
      tap_cnt   <= '0;
      coef_ptr  <= '0;
      samp_ptr  <= '0;
      rd_vld    <= 1'b0;
      hold      <= '0;
      hold_full <= 1'b0;
      out_valid <= 1'b0;
      out_data  <= '0;
      overrun   <= 1'b0;
    end else begin
      rd_vld    <= issue;
      overrun   <= in_valid && !in_ready;
      out_valid <= 1'b0;
      unique case (state)
        SEQ_IDLE: if (accept) begin
          samp_ptr <= wr_ptr;
          coef_ptr <= '0;
          tap_cnt  <= '0;
          state    <= SEQ_RUN;
          if (hold_full) begin
            out_data  <= hold;
            out_valid <= 1'b1;
          end
        end
        SEQ_RUN: begin
          coef_ptr <= coef_ptr + AW'(1);
          samp_ptr <= samp_ptr - AW'(1);
          tap_cnt  <= tap_cnt + AW'(1);
          if (tap_cnt == AW'(TAPS - 1)) state <= SEQ_DRAIN;
        end
        SEQ_DRAIN: if (!rd_vld && !mac_pending) begin
          hold      <= mac_result;
          hold_full <= 1'b1;
          state     <= SEQ_IDLE;
        end
        default: state <= SEQ_IDLE;
      endcase
    end
  end

  // Window counter used only to check the busy length
  always_ff @(posedge clk) begin
    if (!rst_n)         busy_cnt <= '0;
    else if (accept)    busy_cnt <= '0;
    else if (!in_ready) busy_cnt <= busy_cnt + CW'(1);
  end

  p_busy_after_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !in_ready);
  p_busy_length_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_ready && $past(!in_ready)) |-> (busy_cnt == CW'(TAPS + 3)));
  p_single_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  p_release_on_accept_r5: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(accept));
  p_out_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  p_overrun_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
    overrun |-> $past(in_valid && !in_ready));
endmodule

// File: tb/test_fir_mac_engine.sv
module test_fir_mac_engine;
  localparam int TAPS  = 16;
  localparam int SHIFT = 15;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_ready;
  logic signed [15:0] in_data = '0;
  logic coef_we = 1'b0;
  logic [3:0] coef_addr = '0;
  logic signed [15:0] coef_data = '0;
  logic out_valid;
  logic signed [15:0] out_data;
  logic overrun;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic signed [15:0] m_coef [TAPS];
  logic signed [15:0] m_hist [TAPS];
  logic signed [15:0] prev_exp = '0;
  bit have_prev = 1'b0;

  always #5 clk = ~clk;

  fir_mac_engine i_fir_mac_engine (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .coef_we(coef_we), .coef_addr(coef_addr),
    .coef_data(coef_data), .out_valid(out_valid), .out_data(out_data),
    .overrun(overrun));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic signed [15:0] model_out();
    longint s = 0;
    longint sh;
    for (int k = 0; k < TAPS; k++) s += longint'(m_coef[k]) * longint'(m_hist[k]);
    sh = s >>> SHIFT;
    if (sh > 32767) return 16'sd32767;
    if (sh < -32768) return -16'sd32768;
    return 16'(sh);
  endfunction

  task automatic load_coef(input int idx, input logic signed [15:0] v);
    coef_we = 1'b1; coef_addr = 4'(idx); coef_data = v;
    @(negedge clk);
    coef_we = 1'b0;
    m_coef[idx] = v;
  endtask

  // inj: offer an extra sample in the middle of the busy window
  task automatic send(input logic signed [15:0] x, input bit inj, input string req);
    int cnt;
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_data = x;
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == have_prev, "R5", out_valid, have_prev);
    if (have_prev)
      check(out_data == prev_exp, req, out_data, prev_exp);
    for (int k = TAPS - 1; k > 0; k--) m_hist[k] = m_hist[k-1];
    m_hist[0] = x;
    prev_exp  = model_out();
    have_prev = 1'b1;
    cnt = 0;
    while (!in_ready) begin
      cnt++;
      if (cnt == 2) check(out_valid == 1'b0, "R6", out_valid, 0);
      if (inj && cnt == 6) check(overrun == 1'b1, "R8", overrun, 1);
      if (inj && cnt == 7) check(overrun == 1'b0, "R8", overrun, 0);
      if (inj && cnt == 5) begin
        in_valid = 1'b1; in_data = 16'sh7abc;
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    in_valid = 1'b0;
    check(cnt == TAPS + 3, "R7", cnt, TAPS + 3);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240));
    for (int i = 0; i < TAPS; i++) begin m_coef[i] = '0; m_hist[i] = '0; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check(in_ready == 1'b1, "R1", in_ready, 1);
    check(out_valid == 1'b0, "R1", out_valid, 0);
    check(out_data == 0, "R1", out_data, 0);
    check(overrun == 1'b0, "R1", overrun, 0);

    // R2: only tap 3 set to one half, so the output is a delayed, halved input
    load_coef(3, 16'sd16384);
    for (int i = 0; i < 6; i++) send(16'(i * 1000 - 2000), 1'b0, "R2");

    // R3/R10: random taps and samples, with one overrun injection (R8)
    for (int i = 0; i < TAPS; i++) load_coef(i, 16'($urandom_range(0, 65535)));
    for (int i = 0; i < 40; i++) send(16'($urandom_range(0, 65535)), i == 20, "R3");

    // R10: a burst of zeros longer than the delay line flushes older samples
    for (int i = 0; i < TAPS + 1; i++) send(16'sd0, 1'b0, "R10");

    // R9: full-scale positive then negative drive
    for (int i = 0; i < TAPS; i++) load_coef(i, 16'sd32767);
    for (int i = 0; i < TAPS; i++) send(16'sd32767, 1'b0, "R9");
    for (int i = 0; i < TAPS + 1; i++) send(-16'sd32768, 1'b0, "R9");

    // R4: zero taps after large results must give exactly zero
    for (int i = 0; i < TAPS; i++) load_coef(i, 16'sd0);
    for (int i = 0; i < 3; i++) send(16'sd12000, 1'b0, "R4");

    // flush the last held result
    send(16'sd1, 1'b0, "R3");
    @(negedge clk);
    check(out_valid == 1'b0, "R6", out_valid, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule